// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencer

This block is the control unit of a 32-bit load/store processor whose datapath shares one memory port and one ALU across several clock cycles per instruction. A state register steps through instruction fetch, a common decode step that also reads the register file, and then a short opcode-specific tail. The tail is an execute step, then optionally a memory step, then optionally a register write-back step. Every control output is a function of the current state alone (Moore style), so each datapath action is held stable for one whole cycle.

The sequencer reads the 6-bit opcode field of the instruction register and the ALU zero flag. It drives the memory strobes, the memory address source, the instruction register load, the PC update controls, the ALU operand sources, an ALU operation class for a separate function-field decoder, and the register file write controls. The decode step works out a branch target before the opcode is known. A branch-on-equal that is not taken discards it. All pins are plain control levels. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `mcc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in fetch, and fetch is the state seen in the first cycle after `rst` is released, even when reset arrives mid-instruction.
- R2: Fetch asserts `mem_rd` with `addr_sel`=0 (PC), `ir_wr`, and `pc_wr` with `pc_src`=0 (live ALU result). It sets `alu_src_a`=0 (PC), `alu_src_b`=1 (constant 4) and `alu_class`=0 (add), so PC becomes PC+4.
- R3: Decode follows every fetch and its outputs do not depend on the opcode. It sets `alu_src_a`=0, `alu_src_b`=3 (immediate shifted by two) and `alu_class`=0, and it asserts no memory, IR, PC or register-file write.
- R4: Opcode 0x04 (branch-on-equal) runs fetch, decode and one compare state, then returns to fetch. The compare state sets `alu_src_a`=1 (A), `alu_src_b`=0 (B), `alu_class`=1 (subtract), `pc_wr_cond`=1 and `pc_src`=1 (saved ALU output). `pc_en` is high in that state only when `alu_zero` is high.
- R5: Opcode 0x02 (jump) runs three states. The third state asserts `pc_wr` and `pc_en` with `pc_src`=2 (jump target) and then returns to fetch.
- R6: Opcode 0x00 (R-type) runs four states. The execute state sets `alu_src_a`=1, `alu_src_b`=0 and `alu_class`=2 (function field). The next state asserts `rf_wr` with `wr_reg_sel`=1 (bits 15-11) and `wr_data_sel`=0 (ALU output).
- R7: Opcode 0x2B (store word) runs four states. The address state sets `alu_src_a`=1, `alu_src_b`=2 (sign-extended immediate) and `alu_class`=0. The next state asserts `mem_wr` with `addr_sel`=1.
- R8: Opcode 0x23 (load word) runs five states: the address state, then `mem_rd` with `addr_sel`=1, then `rf_wr` with `wr_reg_sel`=0 (bits 20-16) and `wr_data_sel`=1 (memory data register).
- R9: Any other opcode at the end of decode returns the sequencer to fetch with no write of any kind.
- R10: `mem_rd` and `mem_wr` are never high together, and `pc_en` is never high unless `pc_wr` or `pc_wr_cond` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 saved ALU output |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC write request |
| pc_wr_cond | output | 1 | PC write request qualified by alu_zero |
| pc_en | output | 1 | Effective PC load enable |
| pc_src | output | 2 | Next PC source: 0 ALU result, 1 saved ALU output, 2 jump target |
| alu_src_a | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU operand B: 0 register B, 1 constant 4, 2 immediate, 3 immediate shifted by two |
| alu_class | output | 2 | ALU operation class: 0 add, 1 subtract, 2 function field |
| rf_wr | output | 1 | Register file write enable |
| wr_reg_sel | output | 1 | Destination field: 0 bits 20-16, 1 bits 15-11 |
| wr_data_sel | output | 1 | Write data: 0 saved ALU output, 1 memory data register |

## Verification
Each state has its own output pattern, so a wrong state register value shows up on the pins in the very cycle it is entered. Examples are a write strobe where none belongs, or a decode pattern after a fetch that has the wrong shape. A wrong next-state choice shows up one cycle after decode or after the address step: the sequence gets longer or shorter, or it turns into another class's pattern. The bench therefore compares the whole output vector in every cycle of each instruction class against expected patterns, and it checks that the next fetch pattern appears exactly when the instruction should end.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_ADDR,
    ST_LD_MEM,
    ST_LD_WB,
    ST_ST_MEM,
    ST_R_EXEC,
    ST_R_WB,
    ST_BR_CMP,
    ST_JMP
  } mcc_state_e;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'd0,
    ALU_SUB   = 2'd1,
    ALU_FUNCT = 2'd2
  } alu_class_e;

  localparam logic [1:0] PCS_ALU  = 2'd0;
  localparam logic [1:0] PCS_SAVE = 2'd1;
  localparam logic [1:0] PCS_JUMP = 2'd2;

  localparam logic [1:0] SRCB_REG  = 2'd0;
  localparam logic [1:0] SRCB_FOUR = 2'd1;
  localparam logic [1:0] SRCB_IMM  = 2'd2;
  localparam logic [1:0] SRCB_IMM4 = 2'd3;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       ir_wr;
    logic       pc_wr;
    logic       pc_wr_cond;
    logic [1:0] pc_src;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    alu_class_e alu_class;
    logic       rf_wr;
    logic       wr_reg_sel;
    logic       wr_data_sel;
  } mcc_ctrl_t;

endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
#(
  parameter int unsigned   OPW   = 6,
  parameter logic [OPW-1:0] OP_R  = 'h00,
  parameter logic [OPW-1:0] OP_LW = 'h23,
  parameter logic [OPW-1:0] OP_SW = 'h2B,
  parameter logic [OPW-1:0] OP_BR = 'h04,
  parameter logic [OPW-1:0] OP_J  = 'h02
) (
  input  mcc_state_e     cur,
  input  logic [OPW-1:0] opcode,
  output mcc_state_e     nxt
);

  logic is_r, is_lw, is_sw, is_br, is_j;

  always_comb begin
    is_r  = (opcode == OP_R);
    is_lw = (opcode == OP_LW);
    is_sw = (opcode == OP_SW);
    is_br = (opcode == OP_BR);
    is_j  = (opcode == OP_J);
  end

  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (is_r)               nxt = ST_R_EXEC;
        else if (is_lw || is_sw) nxt = ST_ADDR;
        else if (is_br)         nxt = ST_BR_CMP;
        else if (is_j)          nxt = ST_JMP;
        else                    nxt = ST_FETCH;
      end
      ST_ADDR: begin
        if (is_lw)      nxt = ST_LD_MEM;
        else if (is_sw) nxt = ST_ST_MEM;
        else            nxt = ST_FETCH;
      end
      ST_LD_MEM: nxt = ST_LD_WB;
      ST_R_EXEC: nxt = ST_R_WB;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
  import mcc_pkg::*;
(
  input  mcc_state_e cur,
  output mcc_ctrl_t  ctl
);

  always_comb begin
    ctl = '{default: '0, alu_class: ALU_ADD};
    unique case (cur)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_wr     = 1'b1;
        ctl.pc_wr     = 1'b1;
        ctl.pc_src    = PCS_ALU;
        ctl.alu_src_b = SRCB_FOUR;
      end
      ST_DECODE: ctl.alu_src_b = SRCB_IMM4;
      ST_ADDR: begin
        ctl.alu_src_a = 1'b1;
        ctl.alu_src_b = SRCB_IMM;
      end
      ST_LD_MEM: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LD_WB: begin
        ctl.rf_wr       = 1'b1;
        ctl.wr_data_sel = 1'b1;
      end
      ST_ST_MEM: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_R_EXEC: begin
        ctl.alu_src_a = 1'b1;
        ctl.alu_src_b = SRCB_REG;
        ctl.alu_class = ALU_FUNCT;
      end
      ST_R_WB: begin
        ctl.rf_wr      = 1'b1;
        ctl.wr_reg_sel = 1'b1;
      end
      ST_BR_CMP: begin
        ctl.alu_src_a  = 1'b1;
        ctl.alu_src_b  = SRCB_REG;
        ctl.alu_class  = ALU_SUB;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_src     = PCS_SAVE;
      end
      ST_JMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = PCS_JUMP;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mcc_ctrl_fsm.sv
module mcc_ctrl_fsm
  import mcc_pkg::*;
#(
  parameter int unsigned   OPW   = 6,
  parameter logic [OPW-1:0] OP_R  = 'h00,
  parameter logic [OPW-1:0] OP_LW = 'h23,
  parameter logic [OPW-1:0] OP_SW = 'h2B,
  parameter logic [OPW-1:0] OP_BR = 'h04,
  parameter logic [OPW-1:0] OP_J  = 'h02
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  input  logic           alu_zero,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           addr_sel,
  output logic           ir_wr,
  output logic           pc_wr,
  output logic           pc_wr_cond,
  output logic           pc_en,
  output logic [1:0]     pc_src,
  output logic           alu_src_a,
  output logic [1:0]     alu_src_b,
  output logic [1:0]     alu_class,
  output logic           rf_wr,
  output logic           wr_reg_sel,
  output logic           wr_data_sel
);

  mcc_state_e state_q, state_d;
  mcc_ctrl_t  ctl;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FETCH;
    else     state_q <= state_d;
  end

  mcc_next_state #(
    .OPW(OPW), .OP_R(OP_R), .OP_LW(OP_LW), .OP_SW(OP_SW),
    .OP_BR(OP_BR), .OP_J(OP_J)
  ) u_next (
    .cur(state_q),
    .opcode(opcode),
    .nxt(state_d)
  );

  mcc_out_decode u_out (
    .cur(state_q),
    .ctl(ctl)
  );

  always_comb begin
    mem_rd      = ctl.mem_rd;
    mem_wr      = ctl.mem_wr;
    addr_sel    = ctl.addr_sel;
    ir_wr       = ctl.ir_wr;
    pc_wr       = ctl.pc_wr;
    pc_wr_cond  = ctl.pc_wr_cond;
    pc_en       = ctl.pc_wr | (ctl.pc_wr_cond & alu_zero);
    pc_src      = ctl.pc_src;
    alu_src_a   = ctl.alu_src_a;
    alu_src_b   = ctl.alu_src_b;
    alu_class   = ctl.alu_class;
    rf_wr       = ctl.rf_wr;
    wr_reg_sel  = ctl.wr_reg_sel;
    wr_data_sel = ctl.wr_data_sel;
  end

endmodule

// File: rtl/mcc_ctrl_checker.sv
module mcc_ctrl_checker (
  input logic       clk,
  input logic       rst,
  input logic       alu_zero,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       addr_sel,
  input logic       ir_wr,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       pc_en,
  input logic [1:0] pc_src,
  input logic [1:0] alu_src_b,
  input logic [1:0] alu_class,
  input logic       rf_wr,
  input logic       wr_reg_sel,
  input logic       wr_data_sel
);

  AST_RESET_TO_FETCH: assert property (@(posedge clk) rst |=> (ir_wr && mem_rd && !addr_sel)); // R1
  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst) ir_wr |=> (alu_src_b == 2'd3 && !mem_rd && !mem_wr && !rf_wr && !pc_wr && !pc_wr_cond && !ir_wr)); // R3
  AST_BRANCH_ENDS: assert property (@(posedge clk) disable iff (rst) pc_wr_cond |=> ir_wr); // R4
  AST_BRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst) (pc_wr_cond && !alu_zero && !pc_wr) |-> !pc_en); // R4
  AST_JUMP_ENDS: assert property (@(posedge clk) disable iff (rst) (pc_wr && pc_src == 2'd2) |=> ir_wr); // R5
  AST_RTYPE_WB_ORDER: assert property (@(posedge clk) disable iff (rst) (rf_wr && wr_reg_sel) |-> $past(alu_class == 2'd2)); // R6
  AST_LOAD_WB_ORDER: assert property (@(posedge clk) disable iff (rst) (rf_wr && wr_data_sel) |-> $past(mem_rd && addr_sel)); // R8
  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R10
  AST_PC_EN_QUALIFIED: assert property (@(posedge clk) disable iff (rst) pc_en |-> (pc_wr || pc_wr_cond)); // R10

endmodule

bind mcc_ctrl_fsm mcc_ctrl_checker u_chk (
  .clk(clk), .rst(rst), .alu_zero(alu_zero),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_wr(ir_wr),
  .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_en(pc_en), .pc_src(pc_src),
  .alu_src_b(alu_src_b), .alu_class(alu_class), .rf_wr(rf_wr),
  .wr_reg_sel(wr_reg_sel), .wr_data_sel(wr_data_sel)
);

// File: tb/mcc_ctrl_fsm_bench.sv
`timescale 1ns/1ps
module mcc_ctrl_fsm_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       alu_zero = 1'b0;
  logic mem_rd, mem_wr, addr_sel, ir_wr, pc_wr, pc_wr_cond, pc_en;
  logic [1:0] pc_src, alu_src_b, alu_class;
  logic alu_src_a, rf_wr, wr_reg_sel, wr_data_sel;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mcc_ctrl_fsm u_mcc_ctrl_fsm (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_wr(ir_wr),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_en(pc_en), .pc_src(pc_src),
    .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_class(alu_class),
    .rf_wr(rf_wr), .wr_reg_sel(wr_reg_sel), .wr_data_sel(wr_data_sel)
  );

  // bit order: mrd mwr asel irw pcw pcc psrc[2] sa sb[2] cls[2] rfw wrs wds
  function automatic logic [15:0] pat(input logic mrd, input logic mwr, input logic asel,
      input logic irw, input logic pcw, input logic pcc, input logic [1:0] ps,
      input logic sa, input logic [1:0] sb, input logic [1:0] cls,
      input logic rfw, input logic wrs, input logic wds);
    return {mrd, mwr, asel, irw, pcw, pcc, ps, sa, sb, cls, rfw, wrs, wds};
  endfunction

  wire [15:0] sig = {mem_rd, mem_wr, addr_sel, ir_wr, pc_wr, pc_wr_cond, pc_src,
                     alu_src_a, alu_src_b, alu_class, rf_wr, wr_reg_sel, wr_data_sel};

  localparam logic [15:0] P_FETCH = {1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,2'd1,2'd0,1'b0,1'b0,1'b0};
  localparam logic [15:0] P_DEC   = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd3,2'd0,1'b0,1'b0,1'b0};
  localparam logic [15:0] P_ADDR  = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1,2'd2,2'd0,1'b0,1'b0,1'b0};
  localparam logic [15:0] P_LDM   = {1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0};
  localparam logic [15:0] P_LWB   = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,2'd0,1'b1,1'b0,1'b1};
  localparam logic [15:0] P_STM   = {1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0};
  localparam logic [15:0] P_REX   = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1,2'd0,2'd2,1'b0,1'b0,1'b0};
  localparam logic [15:0] P_RWB   = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,2'd0,1'b1,1'b1,1'b0};
  localparam logic [15:0] P_BR    = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,1'b1,2'd0,2'd1,1'b0,1'b0,1'b0};
  localparam logic [15:0] P_JMP   = {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd2,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0};

  task automatic chk(input logic [15:0] exp, input logic exp_en, input string req, input string what);
    total++;
    if (sig !== exp || pc_en !== exp_en) begin
      bad++;
      $display("FAIL %s %s: outputs=%h pc_en=%b expected=%h pc_en=%b", req, what, sig, pc_en, exp, exp_en);
    end
  endtask

  // sample at negedge, then move on one state
  task automatic step(input logic [15:0] exp, input logic exp_en, input string req, input string what);
    chk(exp, exp_en, req, what);
    @(negedge clk);
  endtask

  task automatic front(input logic [5:0] op, input logic z, input string req);
    opcode = op;
    alu_zero = z;
    step(P_FETCH, 1'b1, "R2", {req, " fetch"});
    step(P_DEC, 1'b0, "R3", {req, " decode"});
  endtask

  task automatic t_rtype;
    front(6'h00, 1'b0, "R6");
    step(P_REX, 1'b0, "R6", "execute");
    step(P_RWB, 1'b0, "R6", "write rd");
  endtask

  task automatic t_load;
    front(6'h23, 1'b1, "R8");
    step(P_ADDR, 1'b0, "R8", "address");
    step(P_LDM, 1'b0, "R8", "mem read");
    step(P_LWB, 1'b0, "R8", "write rt");
  endtask

  task automatic t_store;
    front(6'h2B, 1'b0, "R7");
    step(P_ADDR, 1'b0, "R7", "address");
    step(P_STM, 1'b0, "R7", "mem write");
  endtask

  task automatic t_branch(input logic z);
    front(6'h04, z, "R4");
    step(P_BR, z, "R4", z ? "taken" : "not taken");
  endtask

  task automatic t_jump;
    front(6'h02, 1'b1, "R5");
    step(P_JMP, 1'b1, "R5", "jump");
  endtask

  task automatic t_unknown(input logic [5:0] op);
    front(op, 1'b1, "R9");
    chk(P_FETCH, 1'b1, "R9", "back to fetch");
  endtask

  task automatic t_reset_mid;
    front(6'h23, 1'b0, "R1");
    chk(P_ADDR, 1'b0, "R1", "address before reset");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(P_FETCH, 1'b1, "R1", "fetch after mid reset");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(P_FETCH, 1'b1, "R1", "after reset");
    t_rtype();
    t_load();
    t_store();
    t_branch(1'b1);
    t_branch(1'b0);
    t_jump();
    t_unknown(6'h3F);
    t_unknown(6'h05);
    t_load();
    t_rtype();
    t_reset_mid();
    chk(P_FETCH, 1'b1, "R10", "final fetch");
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule